// File: doc/BRIEF.md
# SIMD Floating-Point Magnitude Comparator

This unit takes two packed vectors of single-precision floating-point values and, lane by lane, decides whether the magnitude of the first operand beats the magnitude of the second. Each lane of the result becomes a full 32-bit mask: all ones when the test passes, all zeros when it fails. The result is meant to feed bitwise select or blend operations. No condition flags are produced or changed.

A mode pin picks the test: greater-or-equal or strictly-greater. A width pin picks a four-lane (128-bit) or two-lane (64-bit) vector. The arithmetic runs in a fixed standard mode. Subnormal inputs are flushed to zero. Any NaN makes its lane fail. Lane `i` occupies bits `[32*i+31 : 32*i]` of every vector.

Operands arrive on a valid/ready input stream, and results leave on a valid/ready output stream through one register stage. The block raises `in_ready` when its output register is empty, or when the downstream side takes the held result in the same cycle. While `out_valid` is high and `out_ready` is low, the result is frozen and new input is refused. Control pins (`in_wide`, `in_gt`) are sampled together with the operands.

Top module: `simd_mag_cmp`

## Requirements
- R1: With `in_gt`=0, a lane's result is 0xFFFFFFFF when |a| >= |b| and 0x00000000 otherwise. The sign bit (bit 31 of the lane) of both operands is ignored, so +0 and -0 compare equal.
- R2: With `in_gt`=1, a lane's result is 0xFFFFFFFF only when |a| > |b|; equal magnitudes give 0x00000000.
- R3: If either operand of a lane is a NaN (exponent bits 30:23 all ones, fraction bits 22:0 nonzero), that lane's result is 0x00000000 in both modes.
- R4: An operand with exponent bits all zero is treated as zero magnitude. A subnormal compared against zero passes in GE mode and fails in GT mode. Two different subnormals are equal.
- R5: Infinity (exponent all ones, fraction zero) of either sign has a larger magnitude than every finite value. Two infinities have equal magnitude.
- R6: With `in_wide`=0, only lanes 0 and 1 are compared, and result bits 127:64 are zero. With `in_wide`=1, all four lanes are compared.
- R7: An input accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `out_data` with `out_valid` high right after that edge. When no input is accepted and the held result is taken, `out_valid` falls.
- R8: A synchronous reset clears `out_valid`. After reset, `in_ready` is high.
- R9: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_valid` hold and `in_ready` is low. When `out_ready` returns, a new input may be accepted in the same cycle the held result leaves.
- R10: Every valid result lane is either all ones or all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand vectors and controls are present |
| in_ready | output | 1 | Unit can accept an operand set this cycle |
| in_wide | input | 1 | 1 = four lanes (128-bit), 0 = two lanes (64-bit) |
| in_gt | input | 1 | 1 = strictly greater, 0 = greater or equal |
| in_a | input | 128 | First operand vector |
| in_b | input | 128 | Second operand vector |
| out_valid | output | 1 | Result mask is present |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 128 | Per-lane mask result |

## Verification
Each lane computes its result from the current operands alone, so a wrong classification (a missed NaN, an unflushed subnormal, a sign left in place) shows as a wrong mask in that lane in the very next result, one cycle after the operands are accepted. The only state is the output register and its valid flag. If that state is wrong, `out_valid` stays high or drops out of turn, or `out_data` changes while back-pressure is applied, and the stall sequence exposes this in the same cycle.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int unsigned EW    = 32;
  localparam int unsigned EXP_W = 8;
  localparam int unsigned MAN_W = 23;
  localparam int unsigned MAG_W = EW - 1;

  typedef struct packed {
    logic             nan;
    logic [MAG_W-1:0] mag;
  } mag_info_t;
endpackage

// File: rtl/smc_classify.sv
module smc_classify
  import smc_pkg::*;
(
  input  logic [EW-1:0] val,
  output mag_info_t     info
);
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;

  assign expo = val[EW-2 -: EXP_W];
  assign frac = val[MAN_W-1:0];

  always_comb begin
    info.nan = (&expo) && (|frac);
    // sign dropped; zero exponent (zero or subnormal) flushed to magnitude 0
    info.mag = (expo == '0) ? '0 : val[MAG_W-1:0];
  end
endmodule

// File: rtl/smc_lane.sv
module smc_lane
  import smc_pkg::*;
(
  input  logic          en,
  input  logic          gt_mode,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [EW-1:0] mask
);
  mag_info_t ia, ib;
  logic      bigger, same, pass;

  smc_classify u_cls_a (.val(a), .info(ia));
  smc_classify u_cls_b (.val(b), .info(ib));

  always_comb begin
    bigger = ia.mag > ib.mag;
    same   = ia.mag == ib.mag;
    pass   = !ia.nan && !ib.nan && (bigger || (!gt_mode && same));
    mask   = (en && pass) ? '1 : '0;
  end
endmodule

// File: rtl/smc_out_reg.sv
module smc_out_reg #(
  parameter int unsigned WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/simd_mag_cmp.sv
module simd_mag_cmp
  import smc_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_wide,
  input  logic                in_gt,
  input  logic [LANES*EW-1:0] in_a,
  input  logic [LANES*EW-1:0] in_b,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*EW-1:0] out_data
);
  localparam int unsigned VW     = LANES * EW;
  localparam int unsigned NARROW = LANES / 2;

  logic [VW-1:0] mask_vec;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic lane_en;
    if (i < NARROW) begin : g_low
      assign lane_en = 1'b1;
    end else begin : g_high
      assign lane_en = in_wide;
    end
    smc_lane u_lane (
      .en      (lane_en),
      .gt_mode (in_gt),
      .a       (in_a[i*EW +: EW]),
      .b       (in_b[i*EW +: EW]),
      .mask    (mask_vec[i*EW +: EW])
    );
  end

  smc_out_reg #(.WIDTH(VW)) u_oreg (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (mask_vec),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: rtl/smc_checker.sv
module smc_checker #(
  parameter int unsigned LANES = 4,
  parameter int unsigned EW    = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic                in_wide,
  input logic [LANES*EW-1:0] in_a,
  input logic [LANES*EW-1:0] in_b,
  input logic                out_valid,
  input logic                out_ready,
  input logic [LANES*EW-1:0] out_data
);
  localparam int unsigned HALF = LANES * EW / 2;

  logic took;
  logic rst_q = 1'b0;
  assign took = in_valid && in_ready;

  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      p_reset_clear_r8: assert (out_valid === 1'b0);
    end
  end

  p_accept_lat_r7: assert property (@(posedge clk) disable iff (rst)
    took |=> out_valid);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_narrow_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (took && !in_wide) |=> (out_data[LANES*EW-1:HALF] == '0));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    logic nan_a, nan_b;
    logic [EW-1:0] res;
    assign nan_a = (&in_a[i*EW+23 +: 8]) && (|in_a[i*EW +: 23]);
    assign nan_b = (&in_b[i*EW+23 +: 8]) && (|in_b[i*EW +: 23]);
    assign res   = out_data[i*EW +: EW];

    p_lane_mask_r10: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (res == '0 || res == '1));

    p_nan_fail_r3: assert property (@(posedge clk) disable iff (rst)
      (took && (nan_a || nan_b)) |=> (res == '0));
  end
endmodule

bind simd_mag_cmp smc_checker #(.LANES(LANES), .EW(smc_pkg::EW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_wide(in_wide), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/simd_mag_cmp_bench.sv
module simd_mag_cmp_bench;
  localparam logic [31:0] ONE  = 32'h3F80_0000, NONE = 32'hBF80_0000;
  localparam logic [31:0] TWO  = 32'h4000_0000, NTWO = 32'hC000_0000;
  localparam logic [31:0] NTHR = 32'hC040_0000, PZ = 32'h0, NZ = 32'h8000_0000;
  localparam logic [31:0] INF  = 32'h7F80_0000, NINF = 32'hFF80_0000;
  localparam logic [31:0] MAXF = 32'h7F7F_FFFF, QNAN = 32'h7FC0_0000;
  localparam logic [31:0] SNAN = 32'h7F80_0001, NQNAN = 32'hFFC0_0000;
  localparam logic [31:0] T = 32'hFFFF_FFFF, F = 32'h0;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_wide = 1, in_gt = 0, out_ready = 1;
  logic [127:0] in_a = '0, in_b = '0;
  logic in_ready, out_valid;
  logic [127:0] out_data;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  simd_mag_cmp u_simd_mag_cmp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_wide(in_wide), .in_gt(in_gt), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [127:0] v4(logic [31:0] l0, l1, l2, l3);
    return {l3, l2, l1, l0};
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one operand set at a falling edge, sample result at the next one
  task automatic send(logic [127:0] a, logic [127:0] b, logic wide, logic gt);
    in_a = a; in_b = b; in_wide = wide; in_gt = gt; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    check("R8 out_valid", {127'b0, out_valid}, 128'd0);
    check("R8 in_ready", {127'b0, in_ready}, 128'd1);
  endtask

  task automatic t_ge_sign();
    send(v4(ONE, NTWO, TWO, NZ), v4(NONE, ONE, NTHR, PZ), 1, 0);
    check("R1 valid", {127'b0, out_valid}, 128'd1);
    check("R1 ge", out_data, v4(T, T, F, T));
  endtask

  task automatic t_gt_strict();
    send(v4(ONE, NTWO, TWO, NZ), v4(NONE, ONE, NTHR, PZ), 1, 1);
    check("R2 gt", out_data, v4(F, T, F, F));
  endtask

  task automatic t_nan();
    send(v4(QNAN, ONE, SNAN, NQNAN), v4(ONE, QNAN, PZ, NQNAN), 1, 0);
    check("R3 ge", out_data, '0);
    send(v4(QNAN, ONE, SNAN, NQNAN), v4(ONE, QNAN, PZ, NQNAN), 1, 1);
    check("R3 gt", out_data, '0);
  endtask

  task automatic t_denorm();
    send(v4(32'h1, 32'h0040_0000, 32'h8000_0001, ONE),
         v4(PZ, 32'h1, PZ, 32'h0040_0000), 1, 0);
    check("R4 ge", out_data, v4(T, T, T, T));
    send(v4(32'h1, 32'h0040_0000, 32'h8000_0001, ONE),
         v4(PZ, 32'h1, PZ, 32'h0040_0000), 1, 1);
    check("R4 gt", out_data, v4(F, F, F, T));
  endtask

  task automatic t_inf();
    send(v4(INF, NINF, MAXF, INF), v4(MAXF, INF, NINF, ONE), 1, 0);
    check("R5 ge", out_data, v4(T, T, F, T));
    send(v4(INF, NINF, MAXF, INF), v4(MAXF, INF, NINF, ONE), 1, 1);
    check("R5 gt", out_data, v4(T, F, F, T));
  endtask

  task automatic t_narrow();
    send(v4(TWO, ONE, TWO, TWO), v4(ONE, TWO, PZ, PZ), 0, 0);
    check("R6 narrow", out_data, v4(T, F, F, F));
    send(v4(TWO, ONE, TWO, TWO), v4(ONE, TWO, PZ, PZ), 1, 0);
    check("R6 wide", out_data, v4(T, F, T, T));
  endtask

  task automatic t_latency();
    send(v4(ONE, ONE, ONE, ONE), v4(PZ, PZ, PZ, PZ), 1, 0);
    check("R7 valid after accept", {127'b0, out_valid}, 128'd1);
    @(negedge clk);
    check("R7 valid drops", {127'b0, out_valid}, 128'd0);
  endtask

  task automatic t_stall();
    out_ready = 0;
    send(v4(TWO, TWO, TWO, TWO), v4(ONE, ONE, ONE, ONE), 1, 0);
    check("R9 held A", out_data, v4(T, T, T, T));
    check("R9 in_ready low", {127'b0, in_ready}, 128'd0);
    in_a = v4(ONE, ONE, ONE, ONE); in_b = v4(TWO, TWO, TWO, TWO);
    in_valid = 1;
    @(negedge clk);
    check("R9 still A", out_data, v4(T, T, T, T));
    check("R9 still valid", {127'b0, out_valid}, 128'd1);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R9 B taken", out_data, v4(F, F, F, F));
    check("R9 B valid", {127'b0, out_valid}, 128'd1);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_ge_sign();
    t_gt_strict();
    t_nan();
    t_denorm();
    t_inf();
    t_narrow();
    t_latency();
    t_stall();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule